// File: doc/BRIEF.md
# Serial Clock and Parameter RAM Controller

This block models a timekeeping chip with a small non-volatile parameter memory that a host reaches through three port lines driven by software: an active-low enable, a serial clock and one data line whose direction the host chooses. The host shifts command and data bytes in, most significant bit first, and the block answers read commands by shifting a reply byte back out on the following clock pulses.

Inside are a 32-bit seconds counter advanced by a one-cycle tick pulse, a byte-wide parameter RAM, a write-protect flag and a decoder for single-byte reads, two-byte writes and three-byte extended (sector plus address) accesses. A count of zero stands for midnight at the start of 1 January 1904. All lines are sampled in the `clk_i` domain, so the serial clock must be much slower than `clk_i`.

Top module: `rtc_pram_ctrl`

## Requirements
- R1: While `ce_ni` is high, serial clock edges neither shift bits in nor shift bits out, and no state changes; the partial byte count is kept.
- R2: With `ce_ni` low and `dir_i` high, each rising edge of `sclk_i` shifts `data_i` in, most significant bit first; every eighth such edge completes a byte.
- R3: With `ce_ni` low and `dir_i` low, each falling edge of `sclk_i` drives the next reply bit on `data_o`, most significant bit first, until the 8 bits are used; further falling edges leave `data_o` unchanged. `data_o` resets to 0.
- R4: A command byte with bit 7 set is a read; read commands 0x81, 0x85, 0x89 and 0x8D (command bits 3:2 select byte n) return byte n of the seconds counter, byte 0 being the least significant.
- R5: Write commands 0x01, 0x05, 0x09 and 0x0D take the next byte as data and load it into seconds byte n (command bits 3:2).
- R6: The seconds counter resets to the parameter `SEC_INIT` (default 0) and increases by one on each cycle `tick_i` is high.
- R7: The write-protect flag resets to 1; command 0x35 followed by a data byte loads the flag from data bit 0, and while it is 1 every other data write (seconds, RAM) is discarded.
- R8: A command whose bits 6:4 are 010 and bits 1:0 are 01 (0x21 and 0xA1 families) reaches RAM index 16 plus command bits 3:2: bit 7 set reads it, clear writes the next byte to it.
- R9: A command whose bits 6:3 are 0111 is extended, sector = bits 2:0; the next byte carries an address in bits 6:2, giving RAM index sector*8 + address. With bit 7 set (0xB8 to 0xBF) that byte starts the reply; with bit 7 clear (0x38 to 0x3F) a third byte is written there.
- R10: Command 0x31 takes one data byte and discards it; the byte after it is decoded as a new command.
- R11: A read command that matches none of the forms above loads no reply, so `data_o` stays unchanged on the following falling edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Serial enable, active low |
| sclk_i | input | 1 | Serial clock from the host |
| dir_i | input | 1 | 1: host drives the data line, 0: block drives it |
| data_i | input | 1 | Serial data from the host |
| data_o | output | 1 | Serial reply bit to the host |
| tick_i | input | 1 | One-cycle pulse advancing the seconds counter |

## Verification
A wrong bit count or phase in the decoder shows at the ports as a misframed byte: the next read returns a shifted or unrelated value, at the latest one transaction after the fault. A wrong protect flag or RAM index stays hidden until the same location is read back, so the bench pairs writes with later reads across sectors, the small area and the seconds bytes, including an alias between an extended index and the small area. Reply shifting errors show within the 8 falling edges of the affected read.

// File: rtl/rtc_pram_pkg.sv
package rtc_pram_pkg;
  typedef enum logic [1:0] {PH_CMD, PH_DATA, PH_XADDR, PH_XDATA} phase_e;

  localparam logic [7:0] CMD_PROTECT = 8'h35;
  localparam logic [7:0] CMD_TEST    = 8'h31;

  function automatic logic is_ext(input logic [7:0] c);
    return (c & 8'h78) == 8'h38;
  endfunction

  function automatic logic is_sec(input logic [7:0] c);
    return (c & 8'h73) == 8'h01;
  endfunction

  function automatic logic is_small(input logic [7:0] c);
    return (c & 8'h73) == 8'h21;
  endfunction
endpackage

// File: rtl/rtc_shift_port.sv
module rtc_shift_port #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              sclk_i,
  input  logic              dir_i,
  input  logic              data_i,
  output logic              rx_valid_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  input  logic              tx_load_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  output logic              data_o
);
  localparam int CNT_W  = $clog2(BYTE_W);
  localparam int OCNT_W = $clog2(BYTE_W + 1);

  logic              sclk_q, data_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [BYTE_W-2:0] sh_in_q;
  logic [BYTE_W-1:0] sh_out_q;
  logic [OCNT_W-1:0] out_cnt_q;
  logic              rise, fall, shift_in, shift_out;

  assign rise      = sclk_i & ~sclk_q;
  assign fall      = ~sclk_i & sclk_q;
  assign shift_in  = ~ce_ni & rise & dir_i;
  assign shift_out = ~ce_ni & fall & ~dir_i & (out_cnt_q != '0);

  assign rx_valid_o = shift_in & (bit_cnt_q == CNT_W'(BYTE_W - 1));
  assign rx_byte_o  = {sh_in_q, data_i};
  assign data_o     = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q    <= 1'b0;
      data_q    <= 1'b0;
      bit_cnt_q <= '0;
      sh_in_q   <= '0;
      sh_out_q  <= '0;
      out_cnt_q <= '0;
    end else begin
      sclk_q <= sclk_i;
      if (shift_in) begin
        sh_in_q   <= {sh_in_q[BYTE_W-3:0], data_i};
        bit_cnt_q <= bit_cnt_q + 1'b1;
      end
      if (tx_load_i) begin
        sh_out_q  <= tx_byte_i;
        out_cnt_q <= OCNT_W'(BYTE_W);
      end else if (shift_out) begin
        data_q    <= sh_out_q[BYTE_W-1];
        sh_out_q  <= {sh_out_q[BYTE_W-2:0], 1'b0};
        out_cnt_q <= out_cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
  parameter int          SEC_W    = 32,
  parameter logic [31:0] SEC_INIT = 32'd0,
  localparam int         SEL_W    = $clog2(SEC_W / 8)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [7:0]       wr_byte_i,
  output logic [SEC_W-1:0] count_o
);
  logic [SEC_W-1:0] count_q, count_d;

  always_comb begin
    count_d = count_q + SEC_W'(tick_i);
    if (wr_en_i) count_d[8*wr_sel_i +: 8] = wr_byte_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_q <= SEC_W'(SEC_INIT);
    else         count_q <= count_d;
  end

  assign count_o = count_q;
endmodule

// File: rtl/rtc_cmd_engine.sv
module rtc_cmd_engine
  import rtc_pram_pkg::*;
#(
  parameter int RAM_DEPTH  = 256,
  parameter int SMALL_BASE = 16,
  parameter int SEC_W      = 32,
  localparam int IDX_W     = $clog2(RAM_DEPTH),
  localparam int SEL_W     = $clog2(SEC_W / 8)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_byte_i,
  input  logic [SEC_W-1:0] count_i,
  output logic             sec_wr_o,
  output logic [SEL_W-1:0] sec_sel_o,
  output logic [7:0]       sec_byte_o,
  output logic             tx_load_o,
  output logic [7:0]       tx_byte_o,
  output logic             ram_we_o,
  output logic             wp_o
);
  phase_e           phase_q, phase_d;
  logic [7:0]       cmd_q, cmd_d;
  logic [IDX_W-1:0] xidx_q, xidx_d;
  logic             wp_q, wp_d;
  logic [7:0]       ram_q [RAM_DEPTH];
  logic [IDX_W-1:0] small_rd_idx, small_wr_idx, ext_idx, ram_idx;
  logic             ram_we;

  assign small_rd_idx = IDX_W'(SMALL_BASE) + IDX_W'(rx_byte_i[3:2]);
  assign small_wr_idx = IDX_W'(SMALL_BASE) + IDX_W'(cmd_q[3:2]);
  assign ext_idx      = IDX_W'({cmd_q[2:0], 3'b000}) + IDX_W'(rx_byte_i[6:2]);

  always_comb begin
    phase_d    = phase_q;
    cmd_d      = cmd_q;
    xidx_d     = xidx_q;
    wp_d       = wp_q;
    tx_load_o  = 1'b0;
    tx_byte_o  = '0;
    sec_wr_o   = 1'b0;
    sec_sel_o  = cmd_q[3:2];
    sec_byte_o = rx_byte_i;
    ram_we     = 1'b0;
    ram_idx    = small_wr_idx;
    if (rx_valid_i) begin
      unique case (phase_q)
        PH_CMD: begin
          cmd_d = rx_byte_i;
          if (is_ext(rx_byte_i)) begin
            phase_d = PH_XADDR;
          end else if (!rx_byte_i[7]) begin
            phase_d = PH_DATA;
          end else if (is_sec(rx_byte_i)) begin
            tx_load_o = 1'b1;
            tx_byte_o = count_i[8*rx_byte_i[3:2] +: 8];
          end else if (is_small(rx_byte_i)) begin
            tx_load_o = 1'b1;
            tx_byte_o = ram_q[small_rd_idx];
          end
        end
        PH_DATA: begin
          phase_d = PH_CMD;
          if (cmd_q == CMD_PROTECT) wp_d = rx_byte_i[0];
          else if (!wp_q && is_sec(cmd_q)) sec_wr_o = 1'b1;
          else if (!wp_q && is_small(cmd_q)) ram_we = 1'b1;
        end
        PH_XADDR: begin
          if (cmd_q[7]) begin
            phase_d   = PH_CMD;
            tx_load_o = 1'b1;
            tx_byte_o = ram_q[ext_idx];
          end else begin
            phase_d = PH_XDATA;
            xidx_d  = ext_idx;
          end
        end
        PH_XDATA: begin
          phase_d = PH_CMD;
          ram_idx = xidx_q;
          ram_we  = !wp_q;
        end
        default: phase_d = PH_CMD;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_CMD;
      cmd_q   <= '0;
      xidx_q  <= '0;
      wp_q    <= 1'b1;
      for (int i = 0; i < RAM_DEPTH; i++) ram_q[i] <= '0;
    end else begin
      phase_q <= phase_d;
      cmd_q   <= cmd_d;
      xidx_q  <= xidx_d;
      wp_q    <= wp_d;
      if (ram_we) ram_q[ram_idx] <= rx_byte_i;
    end
  end

  assign ram_we_o = ram_we;
  assign wp_o     = wp_q;
endmodule

// File: rtl/rtc_pram_ctrl.sv
module rtc_pram_ctrl #(
  parameter int          RAM_DEPTH  = 256,
  parameter int          SMALL_BASE = 16,
  parameter int          SEC_W      = 32,
  parameter logic [31:0] SEC_INIT   = 32'd0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic sclk_i,
  input  logic dir_i,
  input  logic data_i,
  output logic data_o,
  input  logic tick_i
);
  localparam int SEL_W = $clog2(SEC_W / 8);

  logic             rx_valid, tx_load, sec_wr, ram_we, wp;
  logic [7:0]       rx_byte, tx_byte, sec_byte;
  logic [SEL_W-1:0] sec_sel;
  logic [SEC_W-1:0] count;

  rtc_shift_port #(.BYTE_W(8)) u_port (
    .clk_i, .rst_ni, .ce_ni, .sclk_i, .dir_i, .data_i,
    .rx_valid_o(rx_valid), .rx_byte_o(rx_byte),
    .tx_load_i(tx_load), .tx_byte_i(tx_byte), .data_o
  );

  rtc_cmd_engine #(
    .RAM_DEPTH(RAM_DEPTH), .SMALL_BASE(SMALL_BASE), .SEC_W(SEC_W)
  ) u_engine (
    .clk_i, .rst_ni,
    .rx_valid_i(rx_valid), .rx_byte_i(rx_byte), .count_i(count),
    .sec_wr_o(sec_wr), .sec_sel_o(sec_sel), .sec_byte_o(sec_byte),
    .tx_load_o(tx_load), .tx_byte_o(tx_byte),
    .ram_we_o(ram_we), .wp_o(wp)
  );

  rtc_sec_counter #(.SEC_W(SEC_W), .SEC_INIT(SEC_INIT)) u_sec (
    .clk_i, .rst_ni, .tick_i,
    .wr_en_i(sec_wr), .wr_sel_i(sec_sel), .wr_byte_i(sec_byte),
    .count_o(count)
  );
endmodule

// File: rtl/rtc_pram_ctrl_chk.sv
module rtc_pram_ctrl_chk #(
  parameter int SEC_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ce_ni,
  input logic             sclk_i,
  input logic             dir_i,
  input logic             data_o,
  input logic             tick_i,
  input logic             rx_valid,
  input logic             tx_load,
  input logic             sec_wr,
  input logic             ram_we,
  input logic             wp,
  input logic [SEC_W-1:0] count
);
  assert_disabled_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |=> $stable(data_o));

  assert_byte_on_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid |-> (sclk_i && !$past(sclk_i) && dir_i && !ce_ni));

  assert_reply_on_fall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(data_o) |-> $past(!sclk_i && !dir_i && !ce_ni));

  assert_reply_after_byte_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_load |-> rx_valid);

  assert_tick_counts_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !sec_wr) |=> count == $past(count) + 1'b1);

  assert_protect_blocks_ram_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we |-> !wp);

  assert_protect_blocks_sec_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_wr |-> !wp);
endmodule

bind rtc_pram_ctrl rtc_pram_ctrl_chk #(.SEC_W(SEC_W)) u_chk (
  .clk_i, .rst_ni, .ce_ni, .sclk_i, .dir_i, .data_o, .tick_i,
  .rx_valid, .tx_load, .sec_wr, .ram_we, .wp, .count
);

// File: tb/rtc_pram_ctrl_bench.sv
module rtc_pram_ctrl_bench;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic ce_ni = 1'b0, sclk = 1'b0, dir = 1'b1, din = 1'b0, tick = 1'b0;
  logic data_o;

  int checks = 0, fails = 0, cycles = 0;
  logic [7:0]  exp_ram [256];
  logic        exp_wp;
  logic [31:0] exp_sec;

  always #10 clk = ~clk;

  rtc_pram_ctrl u_rtc_pram_ctrl (
    .clk_i(clk), .rst_ni, .ce_ni, .sclk_i(sclk), .dir_i(dir),
    .data_i(din), .data_o, .tick_i(tick)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    dir = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      din = b[i]; sclk = 1'b0; wait_n(2);
      sclk = 1'b1; wait_n(2);
    end
  endtask

  task automatic recv_byte(output logic [7:0] r);
    dir = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      sclk = 1'b0; wait_n(2);
      r[i] = data_o;
      sclk = 1'b1; wait_n(2);
    end
    dir = 1'b1;
  endtask

  function automatic int small_idx(input int a); return 16 + a; endfunction
  function automatic int ext_idx(input int s, input int a); return s * 8 + a; endfunction

  task automatic small_wr(input int a, input logic [7:0] d);
    send_byte(8'h21 | 8'(a << 2)); send_byte(d);
    if (!exp_wp) exp_ram[small_idx(a)] = d;
  endtask

  task automatic small_rd(input int a, output logic [7:0] r);
    send_byte(8'hA1 | 8'(a << 2)); recv_byte(r);
  endtask

  task automatic ext_wr(input int s, input int a, input logic [7:0] d);
    send_byte(8'h38 | 8'(s)); send_byte(8'(a << 2)); send_byte(d);
    if (!exp_wp) exp_ram[ext_idx(s, a)] = d;
  endtask

  task automatic ext_rd(input int s, input int a, output logic [7:0] r);
    send_byte(8'hB8 | 8'(s)); send_byte(8'(a << 2)); recv_byte(r);
  endtask

  task automatic sec_wr(input int n, input logic [7:0] d);
    send_byte(8'h01 | 8'(n << 2)); send_byte(d);
    if (!exp_wp) exp_sec[8*n +: 8] = d;
  endtask

  task automatic sec_rd(input int n, output logic [7:0] r);
    send_byte(8'h81 | 8'(n << 2)); recv_byte(r);
  endtask

  task automatic set_wp(input logic v);
    send_byte(8'h35); send_byte({7'h55, v});
    exp_wp = v;
  endtask

  task automatic pulse_tick();
    tick = 1'b1; wait_n(1); tick = 1'b0; wait_n(1);
    exp_sec++;
  endtask

  initial begin
    logic [7:0] r;
    logic       hold;
    int         seed_dummy;
    for (int i = 0; i < 256; i++) exp_ram[i] = 8'h00;
    exp_wp = 1'b1;
    exp_sec = 32'd0;
    seed_dummy = $urandom(32'h0BADF00D);
    wait_n(3);
    rst_ni = 1'b1;
    wait_n(2);

    // reset state
    chk("R3 reset data_o", {31'b0, data_o}, 32'd0);
    small_rd(0, r); chk("R8 reset ram", {24'b0, r}, 32'h00);
    sec_rd(0, r);   chk("R6 reset seconds", {24'b0, r}, 32'h00);

    // protect set at reset
    small_wr(2, 8'hC3); small_rd(2, r);
    chk("R7 write blocked after reset", {24'b0, r}, 32'h00);

    set_wp(1'b0);
    small_wr(2, 8'hA5); small_rd(2, r);
    chk("R8 small area write/read", {24'b0, r}, 32'hA5);
    small_wr(0, 8'h11); ext_rd(2, 0, r);
    chk("R9 ext index 2*8+0 aliases small area", {24'b0, r}, 32'h11);
    ext_wr(5, 3, 8'h5C); ext_rd(5, 3, r);
    chk("R9 extended write/read", {24'b0, r}, 32'h5C);
    ext_wr(7, 31, 8'h96); ext_rd(7, 31, r);
    chk("R9 top extended index", {24'b0, r}, 32'h96);

    // seconds
    sec_wr(0, 8'h78); sec_wr(1, 8'h56); sec_wr(2, 8'h34); sec_wr(3, 8'h12);
    for (int n = 0; n < 4; n++) begin
      sec_rd(n, r); chk("R4 R5 seconds byte", {24'b0, r}, 32'(exp_sec[8*n +: 8]));
    end
    pulse_tick(); pulse_tick(); pulse_tick();
    sec_rd(0, r); chk("R6 tick advances", {24'b0, r}, 32'h7B);
    sec_wr(0, 8'hFF); pulse_tick(); sec_rd(1, r);
    chk("R6 carry into byte 1", {24'b0, r}, 32'h57);

    // enable high: whole write ignored, framing kept
    ce_ni = 1'b1;
    send_byte(8'h25); send_byte(8'hEE);
    hold = data_o;
    recv_byte(r);
    chk("R1 no reply while disabled", {31'b0, data_o}, {31'b0, hold});
    ce_ni = 1'b0;
    small_rd(1, r); chk("R1 write ignored while disabled", {24'b0, r}, 32'h00);

    // test register
    send_byte(8'h31); send_byte(8'h77);
    small_rd(2, r); chk("R10 test write ignored, framing kept", {24'b0, r}, 32'hA5);

    // reply exhausted and unknown reads
    hold = data_o;
    recv_byte(r);
    chk("R3 no bits after reply used", {24'b0, r}, {24'b0, {8{hold}}});
    send_byte(8'h91);
    recv_byte(r);
    chk("R11 unknown read no reply", {24'b0, r}, {24'b0, {8{hold}}});
    small_rd(0, r); chk("R11 next command decoded", {24'b0, r}, 32'h11);

    // protect again
    set_wp(1'b1);
    ext_wr(5, 3, 8'h00); sec_wr(2, 8'h00);
    ext_rd(5, 3, r); chk("R7 ext write blocked", {24'b0, r}, 32'h5C);
    sec_rd(2, r);    chk("R7 seconds write blocked", {24'b0, r}, 32'h34);

    // constrained random traffic
    for (int k = 0; k < 300; k++) begin
      int op, a, s;
      logic [7:0] d;
      op = $urandom_range(0, 9);
      a  = $urandom_range(0, 31);
      s  = $urandom_range(0, 7);
      d  = 8'($urandom);
      case (op)
        0: set_wp(1'($urandom));
        1: small_wr(a % 4, d);
        2: begin small_rd(a % 4, r);
             chk("R8 random small read", {24'b0, r}, 32'(exp_ram[small_idx(a % 4)])); end
        3, 4: ext_wr(s, a, d);
        5, 6: begin ext_rd(s, a, r);
             chk("R9 random ext read", {24'b0, r}, 32'(exp_ram[ext_idx(s, a)])); end
        7: sec_wr(a % 4, d);
        8: begin sec_rd(a % 4, r);
             chk("R4 random seconds read", {24'b0, r}, 32'(exp_sec[8*(a % 4) +: 8])); end
        default: pulse_tick();
      endcase
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule